// File: doc/BRIEF.md
# Non-cacheable memory region decoder

This block decides, for every physical memory address presented to it, whether the access must bypass the cache. Four programmable regions are each described by a start address and an encoded power-of-two size. Two fixed legacy windows in low memory can also be switched on by control bits. The non-cacheable flag is the OR of every enabled term. It is computed combinationally from the address and the current register contents.

Configuration goes through an index/data port pair, one byte per access. A write to the index port selects a register. A later data-port write or read then targets that register. The index register, the two control registers and the twelve descriptor bytes all clear to zero on reset. After reset every region is disabled and all memory is cacheable. The control bits that do not take part in the decision are stored and driven out as individual enable outputs.

Top module: `nc_region_decoder`

## Requirements
- R1: After reset, every register reads zero, every enable output is low, and `uncacheable` is low for any address.
- R2: A write with `io_sel`=0 latches `io_wdata` as the current index. A read with `io_sel`=0 returns that index. With `io_sel`=1, a write stores into the indexed register and `io_rdata` shows its contents.
- R3: Control register one (index 0xC1) keeps only bit 0. Its bits 7..1 always read as zero.
- R4: Any index other than 0xC0, 0xC1 and 0xC4..0xCF reads 0xFF, and a data write to such an index changes no register.
- R5: Region k (k=0..3) uses indices 0xC4+3k (start address bits 31..24), 0xC5+3k (bits 23..16) and 0xC6+3k (bits 15..12 in the upper nibble, size code in the lower nibble). For a size code c in 1..14, the region spans 2^(11+c) bytes. An address matches when its bits 31..(11+c) equal the same bits of the start address, so start bits below the size are ignored.
- R6: Size code 0 disables a region. Size code 15 makes the region match every address.
- R7: When control register zero (index 0xC0) bit 0 is set, any address with bits 19..16 all zero is non-cacheable.
- R8: When control register zero bit 1 is set, addresses 0x000A0000 to 0x000FFFFF are non-cacheable, and addresses outside that range are not affected by this bit.
- R9: Control register zero bits 2..7 drive `a20m_en`, `ken_en`, `flush_en`, `hold_flush`, `direct_map` and `suspend_en` in that order. Control register one bit 0 drives `repl_en`.
- R10: `uncacheable` is the OR of all region matches and both legacy terms. It follows a change of `mem_addr` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_sel | input | 1 | 0 = index port, 1 = data port |
| io_wr | input | 1 | Write strobe for the selected port |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte from the selected port |
| mem_addr | input | 32 | Physical address to classify |
| uncacheable | output | 1 | Address must not be cached |
| a20m_en | output | 1 | Control zero bit 2 |
| ken_en | output | 1 | Control zero bit 3 |
| flush_en | output | 1 | Control zero bit 4 |
| hold_flush | output | 1 | Control zero bit 5 |
| direct_map | output | 1 | Control zero bit 6 |
| suspend_en | output | 1 | Control zero bit 7 |
| repl_en | output | 1 | Control one bit 0 |

## Verification
The assertions take for granted that `io_sel`, `io_wr` and `io_wdata` are stable around each rising edge and never unknown once reset is released. They also assume that the software model holds the index across the data-port access that follows it. The stimulus changes the port inputs only at falling edges and always writes the index before the data byte that uses it. It does not check start-address alignment, because misaligned starts are a legal input whose low bits the design must ignore, and the bench feeds one on purpose.

// File: rtl/nc_region_decoder.sv
module nc_region_decoder #(
  parameter int NREG = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_sel,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [31:0] mem_addr,
  output logic        uncacheable,
  output logic        a20m_en,
  output logic        ken_en,
  output logic        flush_en,
  output logic        hold_flush,
  output logic        direct_map,
  output logic        suspend_en,
  output logic        repl_en
);
  localparam int DBYTES = 3 * NREG;
  localparam int OFF_W  = $clog2(DBYTES);
  localparam int DBASE  = 'hC4;
  localparam logic [7:0] CTL0 = 8'hC0;
  localparam logic [7:0] CTL1 = 8'hC1;

  logic [7:0]       idx_q;
  logic [7:0]       ctl0_q;
  logic             ctl1_q;
  logic [7:0]       desc_q [DBYTES];
  logic             in_desc;
  logic [OFF_W-1:0] doff;
  logic [NREG-1:0]  hit;
  logic             low64, vga;

  assign in_desc = (int'(idx_q) >= DBASE) && (int'(idx_q) < DBASE + DBYTES);
  assign doff    = OFF_W'(int'(idx_q) - DBASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      ctl0_q <= '0;
      ctl1_q <= 1'b0;
      for (int i = 0; i < DBYTES; i++) desc_q[i] <= '0;
    end else if (io_wr) begin
      if (!io_sel)             idx_q        <= io_wdata;
      else if (idx_q == CTL0)  ctl0_q       <= io_wdata;
      else if (idx_q == CTL1)  ctl1_q       <= io_wdata[0];
      else if (in_desc)        desc_q[doff] <= io_wdata;
    end
  end

  always_comb begin
    if (!io_sel)            io_rdata = idx_q;
    else if (idx_q == CTL0) io_rdata = ctl0_q;
    else if (idx_q == CTL1) io_rdata = {7'd0, ctl1_q};
    else if (in_desc)       io_rdata = desc_q[doff];
    else                    io_rdata = 8'hFF;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_region
    logic [31:0] start;
    logic [31:0] mask;
    logic [3:0]  code;
    assign start = {desc_q[3*g], desc_q[3*g+1], desc_q[3*g+2][7:4], 12'h000};
    assign code  = desc_q[3*g+2][3:0];
    assign mask  = (code == 4'hF) ? 32'h0 : (32'hFFFF_FFFF << (32'(code) + 32'd11));
    assign hit[g] = (code != 4'h0) && (((mem_addr ^ start) & mask) == 32'h0);
  end

  assign low64 = ctl0_q[0] && (mem_addr[19:16] == 4'h0);
  assign vga   = ctl0_q[1] && (mem_addr[31:20] == 12'h0) && (mem_addr[19:17] >= 3'd5);
  assign uncacheable = (|hit) | low64 | vga;

  assign a20m_en    = ctl0_q[2];
  assign ken_en     = ctl0_q[3];
  assign flush_en   = ctl0_q[4];
  assign hold_flush = ctl0_q[5];
  assign direct_map = ctl0_q[6];
  assign suspend_en = ctl0_q[7];
  assign repl_en    = ctl1_q;
endmodule

module nc_region_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_sel,
  input logic       io_wr,
  input logic [7:0] io_wdata,
  input logic [7:0] io_rdata,
  input logic [7:0] idx_q,
  input logic       uncacheable,
  input logic       a20m_en,
  input logic       ken_en,
  input logic       flush_en,
  input logic       hold_flush,
  input logic       direct_map,
  input logic       suspend_en,
  input logic       repl_en
);
  logic [5:0] flags;
  logic       mapped;
  assign flags  = {suspend_en, direct_map, hold_flush, flush_en, ken_en, a20m_en};
  assign mapped = (idx_q == 8'hC0) || (idx_q == 8'hC1) || ((idx_q >= 8'hC4) && (idx_q <= 8'hCF));

  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!uncacheable && flags == 6'd0 && !repl_en));

  // R2
  index_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_sel) |=> (idx_q == $past(io_wdata)));

  // R3
  ctl1_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel && idx_q == 8'hC1) |-> (io_rdata[7:1] == 7'd0));

  // R4
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel && !mapped) |-> (io_rdata == 8'hFF));

  // R4
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_sel && !mapped) |=> ($stable(flags) && $stable(repl_en)));

  // R9
  flags_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_sel && idx_q == 8'hC0) |=> (flags == $past(io_wdata[7:2])));
endmodule

bind nc_region_decoder nc_region_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_wdata(io_wdata),
  .io_rdata(io_rdata), .idx_q(idx_q), .uncacheable(uncacheable),
  .a20m_en(a20m_en), .ken_en(ken_en), .flush_en(flush_en), .hold_flush(hold_flush),
  .direct_map(direct_map), .suspend_en(suspend_en), .repl_en(repl_en)
);

// File: tb/test_nc_region_decoder.sv
module test_nc_region_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_sel = 1'b0, io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic [31:0] mem_addr = '0;
  logic uncacheable, a20m_en, ken_en, flush_en, hold_flush, direct_map, suspend_en, repl_en;

  always #2 clk = ~clk;

  nc_region_decoder i_nc_region_decoder (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .mem_addr(mem_addr), .uncacheable(uncacheable),
    .a20m_en(a20m_en), .ken_en(ken_en), .flush_en(flush_en), .hold_flush(hold_flush),
    .direct_map(direct_map), .suspend_en(suspend_en), .repl_en(repl_en)
  );

  typedef struct { int kind; logic [31:0] exp; string req; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = {24'd0, io_rdata};
        1: act = {31'd0, uncacheable};
        default: act = {25'd0, repl_en, suspend_en, direct_map, hold_flush, flush_en, ken_en, a20m_en};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    io_sel = sel; io_wdata = d; io_wr = 1'b1;
    @(posedge clk);
    #1 io_wr = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] v);
    wr(1'b0, idx);
    wr(1'b1, v);
  endtask

  task automatic check_rd(input logic [7:0] idx, input logic [7:0] e, input string req);
    item_t it;
    wr(1'b0, idx);
    @(negedge clk);
    io_sel = 1'b1;
    it.kind = 0; it.exp = {24'd0, e}; it.req = req;
    q.push_back(it);
  endtask

  task automatic check_nc(input logic [31:0] a, input logic e, input string req);
    item_t it;
    @(negedge clk);
    mem_addr = a;
    it.kind = 1; it.exp = {31'd0, e}; it.req = req;
    q.push_back(it);
  endtask

  task automatic check_flags(input logic [6:0] e, input string req);
    item_t it;
    @(negedge clk);
    it.kind = 2; it.exp = {25'd0, e}; it.req = req;
    q.push_back(it);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check_flags(7'd0, "R1 flags");
    check_nc(32'h000A0000, 1'b0, "R1 nc vga");
    check_nc(32'h00000000, 1'b0, "R1 nc zero");
    check_rd(8'hC0, 8'h00, "R1 ctl0");
    check_rd(8'hC1, 8'h00, "R1 ctl1");
    for (int i = 'hC4; i < 'hD0; i++) check_rd(8'(i), 8'h00, "R1 desc");
    // R2 index port readback
    wr(1'b0, 8'h5A);
    @(negedge clk); io_sel = 1'b0;
    begin item_t it; it.kind = 0; it.exp = 32'h5A; it.req = "R2 index read"; q.push_back(it); end
    // R3
    set_reg(8'hC1, 8'hFF);
    check_rd(8'hC1, 8'h01, "R3 ctl1 reserved");
    check_flags(7'h40, "R9 repl_en");
    set_reg(8'hC1, 8'h00);
    // R4
    check_rd(8'h00, 8'hFF, "R4 idx 00");
    check_rd(8'hC2, 8'hFF, "R4 idx C2");
    check_rd(8'hD0, 8'hFF, "R4 idx D0");
    set_reg(8'hC2, 8'hAB);
    set_reg(8'hC3, 8'hFF);
    check_rd(8'hC0, 8'h00, "R4 ctl0 untouched");
    check_rd(8'hC1, 8'h00, "R4 ctl1 untouched");
    check_flags(7'd0, "R4 flags untouched");
    check_nc(32'h000A0000, 1'b0, "R4 nc untouched");
    // R9 / R2
    set_reg(8'hC0, 8'hFC);
    check_rd(8'hC0, 8'hFC, "R2 ctl0 readback");
    check_flags(7'h3F, "R9 all flags");
    check_nc(32'h000A0000, 1'b0, "R9 flags not legacy");
    set_reg(8'hC0, 8'hA4);
    check_flags(7'h29, "R9 pattern");
    // R7
    set_reg(8'hC0, 8'h01);
    check_nc(32'h1230ABCD, 1'b1, "R7 low64 hit");
    check_nc(32'h1230FFFF, 1'b1, "R7 low64 top");
    check_nc(32'h12310000, 1'b0, "R7 low64 miss");
    check_nc(32'h000A0000, 1'b0, "R7 not vga");
    // R8
    set_reg(8'hC0, 8'h02);
    check_nc(32'h0009FFFF, 1'b0, "R8 below");
    check_nc(32'h000A0000, 1'b1, "R8 lower edge");
    check_nc(32'h000FFFFF, 1'b1, "R8 upper edge");
    check_nc(32'h00100000, 1'b0, "R8 above");
    check_nc(32'h001A0000, 1'b0, "R8 other MB");
    check_nc(32'h00000000, 1'b0, "R8 not low64");
    set_reg(8'hC0, 8'h00);
    // R5 region 0: 4K at 0x12345000
    set_reg(8'hC4, 8'h12); set_reg(8'hC5, 8'h34); set_reg(8'hC6, 8'h51);
    check_rd(8'hC6, 8'h51, "R5 byte2 readback");
    check_nc(32'h12345000, 1'b1, "R5 4K base");
    check_nc(32'h12345FFF, 1'b1, "R5 4K top");
    check_nc(32'h12346000, 1'b0, "R5 4K above");
    check_nc(32'h12344FFF, 1'b0, "R5 4K below");
    // region 1: 32M at 0x40000000
    set_reg(8'hC7, 8'h40); set_reg(8'hC8, 8'h00); set_reg(8'hC9, 8'h0E);
    check_nc(32'h41FFFFFF, 1'b1, "R5 32M top");
    check_nc(32'h42000000, 1'b0, "R5 32M above");
    check_nc(32'h3FFFFFFF, 1'b0, "R5 32M below");
    // region 2: 16K, misaligned start 0x00203000
    set_reg(8'hCA, 8'h00); set_reg(8'hCB, 8'h20); set_reg(8'hCC, 8'h33);
    check_nc(32'h00200000, 1'b1, "R5 misaligned base");
    check_nc(32'h00203FFF, 1'b1, "R5 misaligned top");
    check_nc(32'h00204000, 1'b0, "R5 misaligned above");
    // region 3: 1M at 0x00800000
    set_reg(8'hCD, 8'h00); set_reg(8'hCE, 8'h80); set_reg(8'hCF, 8'h09);
    check_nc(32'h008ABCDE, 1'b1, "R5 1M hit");
    check_nc(32'h00900000, 1'b0, "R5 1M miss");
    check_rd(8'hCE, 8'h80, "R2 desc readback");
    // R6
    set_reg(8'hC6, 8'h50);
    check_nc(32'h12345000, 1'b0, "R6 size0 disabled");
    set_reg(8'hC9, 8'h0F);
    check_nc(32'hDEADBEEF, 1'b1, "R6 size15 any");
    check_nc(32'h00000000, 1'b1, "R6 size15 zero");
    set_reg(8'hC9, 8'h0E);
    check_nc(32'hDEADBEEF, 1'b0, "R6 size14 restored");
    // R10 OR of terms, same-cycle response
    set_reg(8'hC0, 8'h02);
    check_nc(32'h000A0000, 1'b1, "R10 legacy with regions");
    check_nc(32'h00201000, 1'b1, "R10 region with legacy");
    check_nc(32'h00500000, 1'b0, "R10 none");
    check_nc(32'h40000000, 1'b1, "R10 next cycle");
    @(negedge clk); @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule